// File: doc/BRIEF.md
# Tagged Receive Byte Queue with Delayed CPU Status

This block sits between a serial frame receiver and a microprocessor. The receiver pushes one byte at a time. Each byte carries a two-bit code that says where the byte sits in its packet. The CPU pops bytes one at a time. It sees the code of the byte at the head of the queue, an empty indication and a high-water indication. The receiver side gets a one-cycle end-of-packet pulse. It also gets a sticky overflow flag, which is set when a byte arrives while the queue already holds its full capacity.

The CPU does not see live status. After every CPU read, the empty flag, the high-water flag and the head code stay frozen until a programmable number of bit-clock strobes has passed. A fast CPU can therefore read again before the status shows that the queue has drained. That read returns the previously delivered byte a second time. This underflow is deliberate and has no flag of its own. The CPU is expected to pace its reads by the high-water flag or by the packet codes.

Top module: `rxf_tagged_fifo`

## Requirements
- R1: After a synchronous reset, the queue is empty. The shown empty flag reads 1, the high-water flag reads 0, overflow reads 0, the end-of-packet pulse reads 0 and read data reads 0x00.
- R2: Bytes come out in the order they were accepted. The byte popped by a read with `rd_en` high appears on `rd_data` in the cycle after that clock edge and stays there until the next read.
- R3: Each stored byte keeps its code: 00 first of packet, 01 middle, 10 last with good check sequence, 11 last with bad check sequence. Once status has refreshed, `rd_tag` shows the code of the head byte.
- R4: The queue holds DEPTH (19) bytes. Once status has refreshed, `hiwater` is 1 exactly when occupancy is THRESH (15) or more.
- R5: A write while the queue is full, with no read in the same cycle, is dropped. It sets `overflow` in the next cycle, and the stored bytes and their order are unchanged.
- R6: `overflow` stays set until a cycle with `ovf_clr` high. If a new overflow happens in that same cycle, the flag stays set.
- R7: A read freezes `empty`, `hiwater` and `rd_tag`. They refresh only once SETTLE_BITS (2) `bit_tick` strobes have occurred after the read, and then one cycle later. With no read pending, they follow the queue state with a one-cycle lag.
- R8: A read while the queue is actually empty returns the previously delivered byte again on `rd_data`, and the queue stays empty.
- R9: `eop` is high for one cycle after an accepted write whose code has bit 1 set (code 10 or 11), and low after any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| wr_en | input | 1 | Push a byte from the receiver |
| wr_data | input | 8 | Byte to push |
| wr_tag | input | 2 | Packet-position code of the pushed byte |
| eop | output | 1 | Pulse after an accepted last-of-packet byte |
| overflow | output | 1 | Sticky flag for a write dropped while full |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Byte delivered by the latest read |
| rd_tag | output | 2 | Shown code of the head byte |
| empty | output | 1 | Shown empty flag |
| hiwater | output | 1 | Shown high-water flag |

## Verification
The hardest case to reach is the redundant-byte underflow. It needs a read of the last byte followed by a second read before any bit strobe arrives, while the frozen status still claims data is present. The stimulus does this by holding `bit_tick` low across back-to-back reads. It checks that the second read repeats the earlier byte and that `empty` only rises after the strobes are then supplied. The full-queue drop is reached by filling all nineteen places, pushing a marked byte and draining the queue to show that the marked byte is absent.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        TAG_FIRST    = 2'b00,
        TAG_MID      = 2'b01,
        TAG_LAST_OK  = 2'b10,
        TAG_LAST_BAD = 2'b11
    } pkt_tag_e;

    typedef struct packed {
        logic     empty;
        logic     hiwater;
        pkt_tag_e tag;
    } cpu_status_t;

    localparam cpu_status_t STATUS_RESET = '{empty: 1'b1, hiwater: 1'b0, tag: TAG_FIRST};
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH  = 19,
    parameter int DATA_W = 8,
    parameter int TAG_W  = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TAG_W-1:0]  push_tag,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DEPTH-1:0]  slot_we;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) d.wr_ptr = advance(q.wr_ptr);
        if (pop)  d.rd_ptr = advance(q.rd_ptr);
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + CNT_W'(1);
            2'b01:   d.cnt = q.cnt - CNT_W'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign slot_we[i] = push && (q.wr_ptr == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
                data_q[i] <= push_data;
                tag_q[i]  <= push_tag;
            end
        end
    end

    assign head_data = data_q[q.rd_ptr];
    assign head_tag  = tag_q[q.rd_ptr];
    assign count     = q.cnt;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= CNT_W'(DEPTH)); // R4
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (q.cnt == '0) |-> !pop); // R8
endmodule

// File: rtl/rxf_settle.sv
module rxf_settle
    import rxf_pkg::*;
#(
    parameter int SETTLE_BITS = 2,
    localparam int SW = $clog2(SETTLE_BITS + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        access,
    input  logic        bit_tick,
    input  cpu_status_t live,
    output cpu_status_t shown
);
    typedef struct packed {
        logic [SW-1:0] wait_cnt;
        cpu_status_t   view;
    } settle_t;

    settle_t q, d;

    always_comb begin
        d = q;
        if (access)
            d.wait_cnt = SW'(SETTLE_BITS);
        else if (bit_tick && q.wait_cnt != '0)
            d.wait_cnt = q.wait_cnt - SW'(1);
        if (!access && q.wait_cnt == '0)
            d.view = live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.wait_cnt <= '0;
            q.view     <= STATUS_RESET;
        end else begin
            q <= d;
        end
    end

    assign shown = q.view;

    AST_FREEZE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        access |=> $stable(shown)); // R7
    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (q.wait_cnt != '0) |=> $stable(shown)); // R7
endmodule

// File: rtl/rxf_tagged_fifo.sv
module rxf_tagged_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH       = 19,
    parameter int THRESH      = 15,
    parameter int DATA_W      = 8,
    parameter int SETTLE_BITS = 2,
    localparam int TAG_W      = 2,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              eop,
    output logic              overflow,
    input  logic              ovf_clr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              empty,
    output logic              hiwater
);
    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              overflow;
        logic              eop;
    } top_t;

    top_t q, d;

    logic              full;
    logic              push;
    logic              pop;
    logic [DATA_W-1:0] head_data;
    logic [TAG_W-1:0]  head_tag;
    logic [CNT_W-1:0]  count;
    cpu_status_t       live;
    cpu_status_t       shown;

    assign full = (count == CNT_W'(DEPTH));
    assign pop  = rd_en && (count != '0);
    assign push = wr_en && (!full || rd_en);

    rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (wr_data),
        .push_tag  (wr_tag),
        .head_data (head_data),
        .head_tag  (head_tag),
        .count     (count)
    );

    always_comb begin
        live.empty   = (count == '0);
        live.hiwater = (count >= CNT_W'(THRESH));
        live.tag     = pkt_tag_e'(head_tag);
    end

    rxf_settle #(.SETTLE_BITS(SETTLE_BITS)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .access   (rd_en),
        .bit_tick (bit_tick),
        .live     (live),
        .shown    (shown)
    );

    always_comb begin
        d = q;
        if (pop) d.rd_data = head_data;
        d.eop = push && wr_tag[1];
        if (wr_en && !push)  d.overflow = 1'b1;
        else if (ovf_clr)    d.overflow = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_data  = q.rd_data;
    assign eop      = q.eop;
    assign overflow = q.overflow;
    assign rd_tag   = shown.tag;
    assign empty    = shown.empty;
    assign hiwater  = shown.hiwater;

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> overflow); // R5
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> $stable(count)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow); // R6
    AST_UNDERFLOW_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && count == '0) |=> $stable(rd_data)); // R8
    AST_EOP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(eop) |-> ($past(wr_en) && $past(wr_tag[1]))); // R9
endmodule

// File: tb/tb_rxf_tagged_fifo.sv
`timescale 1ns/1ps
module tb_rxf_tagged_fifo;
    localparam int DEPTH = 19;
    localparam int THR   = 15;
    localparam int SB    = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_tag = '0;
    logic       eop, overflow, empty, hiwater;
    logic       ovf_clr = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl_d[$];
    logic [1:0] mdl_t[$];
    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [7:0] last_rd = 8'h00;

    always #2 clk = ~clk;

    rxf_tagged_fifo #(.DEPTH(DEPTH), .THRESH(THR), .SETTLE_BITS(SB)) dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .wr_tag(wr_tag), .eop(eop), .overflow(overflow), .ovf_clr(ovf_clr),
        .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .empty(empty), .hiwater(hiwater)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each delivered byte against the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(rd_data == e, r, rd_data, e);
        end
    end

    task automatic wr(input logic [7:0] dat, input logic [1:0] tg);
        bit acc;
        acc = (mdl_d.size() < DEPTH);
        @(posedge clk) #1;
        wr_en = 1'b1; wr_data = dat; wr_tag = tg;
        @(posedge clk) #1;
        wr_en = 1'b0;
        if (acc) begin mdl_d.push_back(dat); mdl_t.push_back(tg); end
        check(eop == (acc && tg[1]), "R9 eop", eop, acc && tg[1]);
    endtask

    task automatic rd(input string req);
        logic [7:0] e;
        @(posedge clk) #1;
        rd_en = 1'b1;
        @(posedge clk) #1;
        rd_en = 1'b0;
        if (mdl_d.size() != 0) begin
            e = mdl_d.pop_front();
            void'(mdl_t.pop_front());
            last_rd = e;
        end else begin
            e = last_rd;
        end
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic settle();
        for (int i = 0; i < SB; i++) begin
            @(posedge clk) #1 bit_tick = 1'b1;
            @(posedge clk) #1 bit_tick = 1'b0;
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic check_status(input string req);
        check(empty == (mdl_d.size() == 0), {req, " empty"}, empty, mdl_d.size() == 0);
        check(hiwater == (mdl_d.size() >= THR), {req, " hiwater"}, hiwater, mdl_d.size() >= THR);
        if (mdl_d.size() != 0)
            check(rd_tag == mdl_t[0], {req, " tag"}, rd_tag, mdl_t[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk) #1;
        // R1 reset state
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(hiwater == 1'b0, "R1 hiwater", hiwater, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);
        check(eop == 1'b0, "R1 eop", eop, 0);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);

        // R3 / R9: one packet with all position codes
        wr(8'h11, 2'b00);
        wr(8'h22, 2'b01);
        wr(8'h33, 2'b01);
        wr(8'h44, 2'b10);
        repeat (2) @(posedge clk); #1;
        check_status("R3");

        // R7: read freezes status until bit strobes arrive
        rd("R2 first");
        repeat (4) @(posedge clk); #1;
        check(rd_tag == 2'b00, "R7 frozen tag", rd_tag, 0);
        settle();
        check_status("R7 refreshed");
        rd("R2"); settle(); check_status("R3 mid");
        rd("R2"); settle(); check_status("R3 last ok");
        rd("R2"); settle(); check_status("R7 drained");

        // R8: underflow returns the previous byte again
        wr(8'h5A, 2'b11);
        settle();
        check_status("R3 last bad");
        rd("R2");
        rd("R8 repeat");
        #1;
        check(empty == 1'b0, "R7 stale empty", empty, 0);
        settle();
        check_status("R8 empty after settle");

        // R4 / R5 / R6: fill, threshold, overflow
        for (int i = 0; i < THR - 1; i++) wr(8'h80 + 8'(i), 2'b01);
        settle();
        check_status("R4 below");
        wr(8'h80 + 8'(THR - 1), 2'b01);
        repeat (2) @(posedge clk); #1;
        check_status("R4 at threshold");
        for (int i = THR; i < DEPTH; i++) wr(8'h80 + 8'(i), 2'b10);
        repeat (2) @(posedge clk); #1;
        check_status("R4 full");
        check(overflow == 1'b0, "R5 no ovf yet", overflow, 0);
        wr(8'hEE, 2'b10);
        check(overflow == 1'b1, "R5 overflow", overflow, 1);
        repeat (5) @(posedge clk); #1;
        check(overflow == 1'b1, "R6 sticky", overflow, 1);
        @(posedge clk) #1 ovf_clr = 1'b1;
        @(posedge clk) #1 ovf_clr = 1'b0;
        check(overflow == 1'b0, "R6 cleared", overflow, 0);
        for (int i = 0; i < DEPTH; i++) rd("R5 content");
        settle();
        check_status("R5 drained");

        // R1: reset mid-operation
        wr(8'h01, 2'b00);
        wr(8'h02, 2'b01);
        @(posedge clk) #1 rst = 1'b1;
        @(posedge clk) #1 rst = 1'b0;
        mdl_d.delete(); mdl_t.delete(); last_rd = 8'h00;
        @(posedge clk) #1;
        check(empty == 1'b1, "R1 empty after reset", empty, 1);
        check(rd_data == 8'h00, "R1 data after reset", rd_data, 0);
        rd("R8 after reset");
        repeat (3) @(posedge clk); #1;

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule